// File: doc/BRIEF.md
# Transport Audio Muting Controller

This block decides, from the operating mode of a tape transport, when the line and monitor audio may be heard, when the level meter is silenced, when the auxiliary audio output relay is closed and when the input of the record amplifier is clamped to ground. An upstream transport controller hands it a decoded mode code. A power-good level and an auto-space request complete the inputs. Every time interval is counted in ticks from an internal prescaler, which divides the system clock.

Audio comes on only in the playing and recording modes. It comes on only after a settling delay, and only while the supply is good. Every other mode mutes the audio on the next clock. The auxiliary output follows the unmuted state, but a record command always disconnects it. During a recording, an auto-space request grounds the record input for a fixed number of ticks, which leaves a blank gap on the tape.

Top module: `tmc_top`

## Requirements
- R1: Mode codes 0 (stop), 1 (rewind), 2 (fast forward), 3 (cue forward), 4 (cue reverse) and 5 (pause) keep `mute_o` at 1. Codes 9 to 15 are undefined and also keep `mute_o` at 1.
- R2: `mute_o` falls only while the mode is 6 (play), 7 (record standby) or 8 (record) and `pwr_ok_i` is 1. It falls after UNMUTE_TICKS ticks. Counted in clock edges from the first edge that samples the qualifying mode, the fall comes no sooner than (UNMUTE_TICKS-1)*TICK_DIV+2 edges and no later than UNMUTE_TICKS*TICK_DIV+1 edges.
- R3: While `pwr_ok_i` is 0, `mute_o` is 1 in every mode. A drop of `pwr_ok_i` raises `mute_o` on the next clock edge.
- R4: `relay_o` is 1 exactly when audio is unmuted and the mode is not 8. Entering mode 8 from an unmuted state clears `relay_o` on the next edge, and `mute_o` stays 0.
- R5: `meter_mute_o` equals `mute_o` in every cycle.
- R6: In mode 8, a one-cycle pulse on `gap_req_i` raises `clamp_o` on the next edge. `clamp_o` then stays high for GAP_TICKS ticks, which lasts from (GAP_TICKS-1)*TICK_DIV+1 to GAP_TICKS*TICK_DIV cycles.
- R7: A request that arrives while `clamp_o` is high does not lengthen the gap. A request in any mode other than 8 is ignored. Leaving mode 8 clears `clamp_o` on the next edge.
- R8: A change from an unmuting mode into a muting mode raises `mute_o` on the next edge, with no delay.
- R9: When the mode leaves the unmuting set, even for a single cycle, the unmute delay starts again from zero on return.
- R10: While `rst_n` is low: `mute_o` = 1, `meter_mute_o` = 1, `relay_o` = 0 and `clamp_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_i | input | 4 | Decoded transport mode code |
| pwr_ok_i | input | 1 | Supply at its correct level |
| gap_req_i | input | 1 | Auto-space request |
| mute_o | output | 1 | Line and monitor mute, 1 = muted |
| meter_mute_o | output | 1 | Level-meter mute, 1 = muted |
| relay_o | output | 1 | Auxiliary output relay enable |
| clamp_o | output | 1 | Record-amplifier input clamp, 1 = grounded |

## Verification
The bench builds the block with TICK_DIV=4, UNMUTE_TICKS=5 and GAP_TICKS=6. With these values the whole unmute delay and the whole auto-space gap last a few dozen cycles, so the bench can measure each interval to the exact cycle and compare it with the window stated in R2 and R6. The divide of 4 also lets the tick fall at different phases relative to mode changes. This exercises the early and late ends of those windows, the delay restart after a one-cycle excursion, and a second gap request in the middle of a gap.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

  typedef enum logic [3:0] {
    MD_STOP     = 4'd0,
    MD_REWIND   = 4'd1,
    MD_FFWD     = 4'd2,
    MD_CUE_FWD  = 4'd3,
    MD_CUE_REV  = 4'd4,
    MD_PAUSE    = 4'd5,
    MD_PLAY     = 4'd6,
    MD_REC_STBY = 4'd7,
    MD_RECORD   = 4'd8
  } xport_mode_e;

  // Modes in which audio may be heard once the settling delay has expired.
  function automatic logic mode_unmutes(input logic [3:0] m);
    return (m == MD_PLAY) || (m == MD_REC_STBY) || (m == MD_RECORD);
  endfunction

  function automatic logic mode_records(input logic [3:0] m);
    return m == MD_RECORD;
  endfunction

endpackage

// File: rtl/tmc_tick.sv
module tmc_tick #(
  parameter int TICK_DIV = 125000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);

  generate
    if (TICK_DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] TOP = CW'(TICK_DIV - 1);

      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == TOP) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == TOP);

      // R2
      tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    end
  endgenerate

endmodule

// File: rtl/tmc_unmute_timer.sv
module tmc_unmute_timer #(
  parameter int UNMUTE_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic open_req_i,
  output logic settled_o
);

  localparam int DW = $clog2(UNMUTE_TICKS + 1);
  localparam logic [DW-1:0] LAST = DW'(UNMUTE_TICKS);

  logic [DW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!open_req_i)                      cnt_d = '0;
    else if (tick_i && (cnt_q != LAST))   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign settled_o = open_req_i && (cnt_q == LAST);

  // R2
  delay_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9
  delay_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_req_i |=> (cnt_q == '0));

endmodule

// File: rtl/tmc_gap_timer.sv
module tmc_gap_timer #(
  parameter int GAP_TICKS = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic arm_i,
  input  logic req_i,
  output logic clamp_o
);

  localparam int GW = (GAP_TICKS > 1) ? $clog2(GAP_TICKS) : 1;
  localparam logic [GW-1:0] LAST = GW'(GAP_TICKS - 1);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          clamp_q, clamp_d;

  always_comb begin
    cnt_d   = cnt_q;
    clamp_d = clamp_q;
    if (!arm_i) begin
      cnt_d   = '0;
      clamp_d = 1'b0;
    end else if (!clamp_q) begin
      if (req_i) begin
        cnt_d   = '0;
        clamp_d = 1'b1;
      end
    end else if (tick_i) begin
      if (cnt_q == LAST) clamp_d = 1'b0;
      else               cnt_d   = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      clamp_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      clamp_q <= clamp_d;
    end
  end

  assign clamp_o = clamp_q;

  // R6
  gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R7
  gap_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_i |=> !clamp_q);

  // R6
  gap_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_i && req_i && !clamp_q) |=> clamp_q);

endmodule

// File: rtl/tmc_top.sv
module tmc_top
  import tmc_pkg::*;
#(
  parameter int TICK_DIV     = 125000,
  parameter int UNMUTE_TICKS = 200,
  parameter int GAP_TICKS    = 4000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode_i,
  input  logic       pwr_ok_i,
  input  logic       gap_req_i,
  output logic       mute_o,
  output logic       meter_mute_o,
  output logic       relay_o,
  output logic       clamp_o
);

  logic tick;
  logic open_req;
  logic settled;
  logic is_rec;

  logic mute_q,  mute_d;
  logic meter_q, meter_d;
  logic relay_q, relay_d;

  assign open_req = mode_unmutes(mode_i) && pwr_ok_i;
  assign is_rec   = mode_records(mode_i);

  tmc_tick #(
    .TICK_DIV (TICK_DIV)
  ) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  tmc_unmute_timer #(
    .UNMUTE_TICKS (UNMUTE_TICKS)
  ) u_unmute (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .open_req_i (open_req),
    .settled_o  (settled)
  );

  tmc_gap_timer #(
    .GAP_TICKS (GAP_TICKS)
  ) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .arm_i   (is_rec),
    .req_i   (gap_req_i),
    .clamp_o (clamp_o)
  );

  always_comb begin
    mute_d  = !settled;
    meter_d = !settled;
    relay_d = settled && !is_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mute_q  <= 1'b1;
      meter_q <= 1'b1;
      relay_q <= 1'b0;
    end else begin
      mute_q  <= mute_d;
      meter_q <= meter_d;
      relay_q <= relay_d;
    end
  end

  assign mute_o       = mute_q;
  assign meter_mute_o = meter_q;
  assign relay_o      = relay_q;

  // R1
  mute_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_unmutes(mode_i) |=> mute_o);

  // R3
  pwr_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok_i |=> mute_o);

  // R2
  release_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> $past(open_req));

  // R4
  relay_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rec |=> !relay_o);

  // R4
  relay_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    relay_o |-> !mute_o);

  // R5
  meter_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    meter_mute_o == mute_o);

endmodule

// File: tb/tmc_top_test.sv
`timescale 1ns/1ps
module tmc_top_test;

  localparam int P = 4;
  localparam int D = 5;
  localparam int G = 6;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] mode;
  logic       pwr_ok;
  logic       gap_req;
  logic       mute, meter_mute, relay, clamp;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tmc_top #(
    .TICK_DIV     (P),
    .UNMUTE_TICKS (D),
    .GAP_TICKS    (G)
  ) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode),
    .pwr_ok_i     (pwr_ok),
    .gap_req_i    (gap_req),
    .mute_o       (mute),
    .meter_mute_o (meter_mute),
    .relay_o      (relay),
    .clamp_o      (clamp)
  );

  // {mode, pwr_ok, expected mute, expected relay}
  localparam logic [6:0] VECS [0:12] = '{
    {4'd0,  1'b1, 1'b1, 1'b0},
    {4'd1,  1'b1, 1'b1, 1'b0},
    {4'd6,  1'b1, 1'b0, 1'b1},
    {4'd2,  1'b1, 1'b1, 1'b0},
    {4'd3,  1'b1, 1'b1, 1'b0},
    {4'd4,  1'b1, 1'b1, 1'b0},
    {4'd5,  1'b1, 1'b1, 1'b0},
    {4'd7,  1'b1, 1'b0, 1'b1},
    {4'd8,  1'b1, 1'b0, 1'b0},
    {4'd6,  1'b0, 1'b1, 1'b0},
    {4'd8,  1'b0, 1'b1, 1'b0},
    {4'd12, 1'b1, 1'b1, 1'b0},
    {4'd15, 1'b1, 1'b1, 1'b0}
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // Negedges from the mode change until mute_o reads 0.
  task automatic measure_release(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (mute && n < 200);
  endtask

  // Pulse gap_req_i; count negedges until clamp_o reads 0.
  task automatic measure_gap(input logic retrig, output int n);
    n = 0;
    gap_req = 1'b1;
    do begin
      @(negedge clk);
      n++;
      gap_req = retrig && (n == 10);
    end while (clamp && n < 200);
    gap_req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    rst_n   = 1'b0;
    mode    = 4'd0;
    pwr_ok  = 1'b1;
    gap_req = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 mute",  mute, 1'b1);
    chk("R10 meter", meter_mute, 1'b1);
    chk("R10 relay", relay, 1'b0);
    chk("R10 clamp", clamp, 1'b0);
    rst_n = 1'b1;

    // Table walk: R1, R2, R3, R4, R5
    for (int i = 0; i < 13; i++) begin
      mode   = VECS[i][6:3];
      pwr_ok = VECS[i][2];
      repeat (30) @(negedge clk);
      chk($sformatf("R1/R2/R3 mute vec%0d", i), mute, VECS[i][1]);
      chk($sformatf("R4 relay vec%0d", i), relay, VECS[i][0]);
      chk($sformatf("R5 meter vec%0d", i), meter_mute, mute);
    end

    // R2 delay window from stop to play
    pwr_ok = 1'b1;
    mode = 4'd0;
    repeat (5) @(negedge clk);
    mode = 4'd6;
    measure_release(n);
    chk_range("R2 release delay", n, (D-1)*P+2, D*P+1);
    chk("R5 meter at release", meter_mute, 1'b0);

    // R8 immediate mute on entry to fast forward
    repeat (3) @(negedge clk);
    mode = 4'd2;
    @(negedge clk);
    chk("R8 mute next edge", mute, 1'b1);
    chk("R8 relay next edge", relay, 1'b0);

    // R9 restart after one-cycle excursion
    mode = 4'd6;
    repeat (12) @(negedge clk);
    chk("R9 still muted mid-delay", mute, 1'b1);
    mode = 4'd5;
    @(negedge clk);
    mode = 4'd6;
    measure_release(n);
    chk_range("R9 restarted delay", n, (D-1)*P+2, D*P+1);

    // R3 power drop mutes next edge, recovery uses full delay
    repeat (3) @(negedge clk);
    pwr_ok = 1'b0;
    @(negedge clk);
    chk("R3 mute on power drop", mute, 1'b1);
    chk("R3 relay on power drop", relay, 1'b0);
    repeat (4) @(negedge clk);
    pwr_ok = 1'b1;
    measure_release(n);
    chk_range("R3 release after power return", n, (D-1)*P+2, D*P+1);

    // R4 record forces relay off, audio stays unmuted
    repeat (2) @(negedge clk);
    chk("R4 relay in play", relay, 1'b1);
    mode = 4'd8;
    @(negedge clk);
    chk("R4 relay off in record", relay, 1'b0);
    chk("R4 mute stays off in record", mute, 1'b0);

    // R6 gap length in record
    repeat (3) @(negedge clk);
    measure_gap(1'b0, n);
    chk_range("R6 gap length", n, (G-1)*P+2, G*P+1);
    chk("R6 mute unaffected by gap", mute, 1'b0);

    // R7 second request during gap does not extend it
    repeat (3) @(negedge clk);
    measure_gap(1'b1, n);
    chk_range("R7 retrigger ignored", n, (G-1)*P+2, G*P+1);

    // R7 request outside record ignored
    mode = 4'd6;
    repeat (3) @(negedge clk);
    gap_req = 1'b1;
    @(negedge clk);
    gap_req = 1'b0;
    chk("R7 no clamp in play", clamp, 1'b0);
    repeat (5) @(negedge clk);
    chk("R7 still no clamp in play", clamp, 1'b0);

    // R7 leaving record ends the clamp on the next edge
    mode = 4'd8;
    repeat (3) @(negedge clk);
    gap_req = 1'b1;
    @(negedge clk);
    gap_req = 1'b0;
    chk("R6 clamp raised", clamp, 1'b1);
    repeat (4) @(negedge clk);
    mode = 4'd5;
    @(negedge clk);
    chk("R7 clamp cleared on leaving record", clamp, 1'b0);
    chk("R8 mute on pause", mute, 1'b1);

    summary();
    $finish;
  end

endmodule